// File: doc/BRIEF.md
# Program and Erase Status Controller

This block runs one self-timed non-volatile operation at a time: a single-word program, a page erase, a block erase or a whole-array erase. A request carries an operation code, a word address and a data word. Once a request is taken, the block stays busy for a fixed number of clock cycles. Each operation kind has its own cycle count, set by a parameter. The block then returns to plain read mode by itself.

While the block is busy, reads do not return array contents. They return a status word instead, so a host can poll for completion through the read path alone. A separate ready/busy enable is also provided. It is meant to pull an external open-drain line low during the operation and to let go of it afterwards.

A small behavioural word array sits inside the block. A program clears bits only: the stored word becomes the old word ANDed with the new one. An erase walks its range at one word per clock and fills each word with all ones. A boot-region lock protects the lowest addresses.

Top module: `pe_status_ctrl`

## Requirements
- R1: A read taken while a program is busy returns a status word. In that word, bit 7 is the inverse of bit 7 of the data being programmed, and bits other than 7 and 6 are 0. Once busy has dropped, a read of the same address returns the stored word.
- R2: A read taken while any erase is busy returns 0 on bit 7, and 0 on every bit other than 6.
- R3: Bit 6 of the status word is 0 on the first read after an operation starts. It inverts on each later read within the same operation.
- R4: Busy and the ready/busy pull-low enable are both high for exactly the operation's duration, counted in cycles. A program lasts PROG_CYC cycles. A page erase lasts the larger of PAGE_CYC and PAGE_WORDS. A block erase lasts the larger of BLOCK_CYC and BLOCK_WORDS. A chip erase lasts the larger of CHIP_CYC and the array depth. The program write pulse comes in the last busy cycle.
- R5: A program stores the old word ANDed with the request data, so bits can only be cleared.
- R6: An erase sets every word in its range to all ones and leaves every other word alone. Op code 2'b01 is a page erase, covering the aligned PAGE_WORDS group. Op code 2'b10 is a block erase, covering the aligned BLOCK_WORDS group. Op code 2'b11 is a chip erase, covering every word. Op code 2'b00 is a word program.
- R7: While lock_i is high, the boot region is protected. The boot region is the addresses below BOOT_WORDS. A program, page erase or block erase whose range starts in the boot region is dropped: busy does not rise and no data changes. A chip erase still runs, but leaves the boot words unchanged.
- R8: A request that arrives while busy is ignored.
- R9: While rst_n is low, the block is held idle. busy_o, rdy_low_o and rd_oe_o are all low. Any running operation is aborted, and an aborted program leaves its word unchanged. After release, the block is in read mode.
- R10: A read strobe produces rd_oe_o and rd_data_o one cycle later. When the block is idle, rd_data_o is the array word at rd_addr_i. rd_oe_o is low in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; aborts any operation |
| req_valid_i | input | 1 | Operation request strobe |
| req_op_i | input | 2 | 00 program, 01 page erase, 10 block erase, 11 chip erase |
| req_addr_i | input | ADDR_W | Target word address |
| req_data_i | input | DATA_W | Program data |
| lock_i | input | 1 | Boot-region lock level |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read word address |
| busy_o | output | 1 | Operation in progress |
| rdy_low_o | output | 1 | Enable for pulling the ready/busy line low |
| rd_oe_o | output | 1 | Read data drive enable, one cycle after rd_i |
| rd_data_o | output | DATA_W | Array word or status word |
| arr_pe_o | output | 1 | Program write pulse toward the array |
| arr_ee_o | output | 1 | Erase fill pulse toward the array |
| arr_addr_o | output | ADDR_W | Array word being written |

## Verification
The hardest case to reach is a chip erase that must step over the locked boot words while still filling the rest of the array. The array has to be seeded with non-erased values first, and the bench does this by programming every address through the normal request port. Only then does it raise the lock and run the locked erase, and a full read-back separates the kept words from the filled ones. The toggle restart is handled in a similar way. The bench polls two operations back to back, with data whose bit 7 is opposite in each, so the first-read value of bit 6 and the bit 7 inversion are both seen twice.

// File: rtl/pesc_pkg.sv
package pesc_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_PAGE  = 2'b01,
        OP_BLOCK = 2'b10,
        OP_CHIP  = 2'b11
    } pe_op_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pesc_range.sv
module pesc_range
    import pesc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned BLOCK_WORDS = 16,
    parameter int unsigned BOOT_WORDS  = 8
) (
    input  pe_op_e              op_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [ADDR_W-1:0]   base_o,
    output logic [ADDR_W:0]     span_o,
    output logic                boot_hit_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] PAGE_MASK  = ~ADDR_W'(PAGE_WORDS - 1);
    localparam logic [ADDR_W-1:0] BLOCK_MASK = ~ADDR_W'(BLOCK_WORDS - 1);

    always_comb begin
        unique case (op_i)
            OP_PROG: begin
                base_o = addr_i;
                span_o = (ADDR_W+1)'(1);
            end
            OP_PAGE: begin
                base_o = addr_i & PAGE_MASK;
                span_o = (ADDR_W+1)'(PAGE_WORDS);
            end
            OP_BLOCK: begin
                base_o = addr_i & BLOCK_MASK;
                span_o = (ADDR_W+1)'(BLOCK_WORDS);
            end
            default: begin
                base_o = '0;
                span_o = (ADDR_W+1)'(DEPTH);
            end
        endcase
        boot_hit_o = ({1'b0, base_o} < (ADDR_W+1)'(BOOT_WORDS));
    end

endmodule

// File: rtl/pesc_dur.sv
module pesc_dur
    import pesc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned CNT_W       = 25,
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned BLOCK_WORDS = 16,
    parameter int unsigned PROG_CYC    = 6250,
    parameter int unsigned PAGE_CYC    = 6250000,
    parameter int unsigned BLOCK_CYC   = 6250000,
    parameter int unsigned CHIP_CYC    = 25000000
) (
    input  pe_op_e             op_i,
    output logic [CNT_W-1:0]   last_o
);
    localparam int unsigned DEPTH     = 1 << ADDR_W;
    localparam int unsigned PROG_EFF  = umax(PROG_CYC, 1);
    localparam int unsigned PAGE_EFF  = umax(PAGE_CYC, PAGE_WORDS);
    localparam int unsigned BLOCK_EFF = umax(BLOCK_CYC, BLOCK_WORDS);
    localparam int unsigned CHIP_EFF  = umax(CHIP_CYC, DEPTH);

    always_comb begin
        unique case (op_i)
            OP_PROG:  last_o = CNT_W'(PROG_EFF - 1);
            OP_PAGE:  last_o = CNT_W'(PAGE_EFF - 1);
            OP_BLOCK: last_o = CNT_W'(BLOCK_EFF - 1);
            default:  last_o = CNT_W'(CHIP_EFF - 1);
        endcase
    end

endmodule

// File: rtl/pesc_array.sv
module pesc_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic                clk,
    input  logic                prog_en_i,
    input  logic                fill_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (prog_en_i) begin
            cells_q[wr_addr_i] <= cells_q[wr_addr_i] & wr_data_i;
        end else if (fill_en_i) begin
            cells_q[wr_addr_i] <= '1;
        end
    end

    assign rd_data_o = cells_q[rd_addr_i];

endmodule

// File: rtl/pe_status_ctrl.sv
module pe_status_ctrl
    import pesc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned BLOCK_WORDS = 16,
    parameter int unsigned BOOT_WORDS  = 8,
    parameter int unsigned PROG_CYC    = 6250,
    parameter int unsigned PAGE_CYC    = 6250000,
    parameter int unsigned BLOCK_CYC   = 6250000,
    parameter int unsigned CHIP_CYC    = 25000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [1:0]          req_op_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_data_i,
    input  logic                lock_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic                busy_o,
    output logic                rdy_low_o,
    output logic                rd_oe_o,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                arr_pe_o,
    output logic                arr_ee_o,
    output logic [ADDR_W-1:0]   arr_addr_o
);
    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned MAX_DUR = umax(umax(umax(PROG_CYC, 1), umax(PAGE_CYC, PAGE_WORDS)),
                                           umax(umax(BLOCK_CYC, BLOCK_WORDS), umax(CHIP_CYC, DEPTH)));
    localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);
    localparam int unsigned POLL_B  = 7;
    localparam int unsigned TOG_B   = 6;

    typedef struct packed {
        logic                busy;
        pe_op_e              op;
        logic                lock;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W:0]     left;
        logic [CNT_W-1:0]    cnt;
        logic [DATA_W-1:0]   wdata;
        logic                tog;
        logic                rdv;
        logic [DATA_W-1:0]   rdata;
    } st_t;

    st_t st_d, st_q;

    pe_op_e             req_op;
    logic [ADDR_W-1:0]  rng_base;
    logic [ADDR_W:0]    rng_span;
    logic               rng_boot;
    logic [CNT_W-1:0]   dur_last;
    logic [DATA_W-1:0]  arr_rdata;
    logic               req_take;
    logic               ptr_in_boot;

    assign req_op = pe_op_e'(req_op_i);

    pesc_range #(
        .ADDR_W      (ADDR_W),
        .PAGE_WORDS  (PAGE_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .BOOT_WORDS  (BOOT_WORDS)
    ) u_range (
        .op_i       (req_op),
        .addr_i     (req_addr_i),
        .base_o     (rng_base),
        .span_o     (rng_span),
        .boot_hit_o (rng_boot)
    );

    pesc_dur #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .PAGE_WORDS  (PAGE_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .PROG_CYC    (PROG_CYC),
        .PAGE_CYC    (PAGE_CYC),
        .BLOCK_CYC   (BLOCK_CYC),
        .CHIP_CYC    (CHIP_CYC)
    ) u_dur (
        .op_i   (req_op),
        .last_o (dur_last)
    );

    pesc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk       (clk),
        .prog_en_i (arr_pe_o),
        .fill_en_i (arr_ee_o),
        .wr_addr_i (arr_addr_o),
        .wr_data_i (st_q.wdata),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (arr_rdata)
    );

    // Refuse requests while busy, and protected-region targets under lock
    // (chip erase always runs; it skips protected words instead).
    assign req_take = req_valid_i && !st_q.busy &&
                      !(lock_i && rng_boot && (req_op != OP_CHIP));

    assign ptr_in_boot = ({1'b0, st_q.ptr} < (ADDR_W+1)'(BOOT_WORDS));

    always_comb begin
        st_d     = st_q;
        st_d.rdv = 1'b0;

        // running operation: countdown and erase walk
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (st_q.left != '0) begin
                st_d.ptr  = st_q.ptr + 1'b1;
                st_d.left = st_q.left - 1'b1;
            end
        end

        // read path: status while busy, array word otherwise
        if (rd_i) begin
            st_d.rdv = 1'b1;
            if (st_q.busy) begin
                st_d.rdata         = '0;
                st_d.rdata[POLL_B] = (st_q.op == OP_PROG) ? ~st_q.wdata[POLL_B] : 1'b0;
                st_d.rdata[TOG_B]  = st_q.tog;
                st_d.tog           = ~st_q.tog;
            end else begin
                st_d.rdata = arr_rdata;
            end
        end

        // launch
        if (req_take) begin
            st_d.busy  = 1'b1;
            st_d.op    = req_op;
            st_d.lock  = lock_i;
            st_d.ptr   = rng_base;
            st_d.left  = (req_op == OP_PROG) ? '0 : rng_span;
            st_d.cnt   = dur_last;
            st_d.wdata = req_data_i;
            st_d.tog   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.busy;
    assign rdy_low_o  = st_q.busy;
    assign rd_oe_o    = st_q.rdv;
    assign rd_data_o  = st_q.rdata;
    assign arr_addr_o = st_q.ptr;
    assign arr_pe_o   = st_q.busy && (st_q.op == OP_PROG) && (st_q.cnt == '0);
    assign arr_ee_o   = st_q.busy && (st_q.op != OP_PROG) && (st_q.left != '0) &&
                        !(st_q.lock && (st_q.op == OP_CHIP) && ptr_in_boot);

endmodule

// File: rtl/pe_status_ctrl_chk.sv
module pe_status_ctrl_chk #(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned BLOCK_WORDS = 16,
    parameter int unsigned BOOT_WORDS  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid_i,
    input logic [1:0]          req_op_i,
    input logic [ADDR_W-1:0]   req_addr_i,
    input logic [DATA_W-1:0]   req_data_i,
    input logic                lock_i,
    input logic                rd_i,
    input logic                busy_o,
    input logic                rdy_low_o,
    input logic                rd_oe_o,
    input logic [DATA_W-1:0]   rd_data_o,
    input logic                arr_pe_o,
    input logic                arr_ee_o,
    input logic [ADDR_W-1:0]   arr_addr_o
);
    logic       busy_prev, op_prog_prev, d7_prev, lock_prev;
    logic       cur_prog_q, cur_d7_q, cur_lock_q, cur_chip_q, op_chip_prev;
    logic       cur_prog, cur_d7, cur_lock, cur_chip, started;
    logic       stat_rd_q, have_prev_q, prev6_q;
    logic [ADDR_W-1:0] req_base;
    logic       req_in_boot;

    assign started  = busy_o && !busy_prev;
    assign cur_prog = started ? op_prog_prev : cur_prog_q;
    assign cur_d7   = started ? d7_prev      : cur_d7_q;
    assign cur_lock = started ? lock_prev    : cur_lock_q;
    assign cur_chip = started ? op_chip_prev : cur_chip_q;

    always_comb begin
        case (req_op_i)
            2'b01:   req_base = req_addr_i & ~ADDR_W'(PAGE_WORDS - 1);
            2'b10:   req_base = req_addr_i & ~ADDR_W'(BLOCK_WORDS - 1);
            default: req_base = req_addr_i;
        endcase
        req_in_boot = ({1'b0, req_base} < (ADDR_W+1)'(BOOT_WORDS)) && (req_op_i != 2'b11);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_prev    <= 1'b0;
            op_prog_prev <= 1'b0;
            op_chip_prev <= 1'b0;
            d7_prev      <= 1'b0;
            lock_prev    <= 1'b0;
            cur_prog_q   <= 1'b0;
            cur_d7_q     <= 1'b0;
            cur_lock_q   <= 1'b0;
            cur_chip_q   <= 1'b0;
            stat_rd_q    <= 1'b0;
            have_prev_q  <= 1'b0;
            prev6_q      <= 1'b0;
        end else begin
            busy_prev    <= busy_o;
            op_prog_prev <= (req_op_i == 2'b00);
            op_chip_prev <= (req_op_i == 2'b11);
            d7_prev      <= req_data_i[7];
            lock_prev    <= lock_i;
            cur_prog_q   <= cur_prog;
            cur_d7_q     <= cur_d7;
            cur_lock_q   <= cur_lock;
            cur_chip_q   <= cur_chip;
            stat_rd_q    <= rd_i && busy_o;
            if (started) begin
                have_prev_q <= 1'b0;
            end else if (stat_rd_q) begin
                if (have_prev_q) begin
                    AST_TOGGLE_FLIP: assert (rd_data_o[6] != prev6_q) else $error("toggle bit did not flip"); // R3
                end else begin
                    AST_TOGGLE_FIRST: assert (rd_data_o[6] == 1'b0) else $error("first toggle read not 0"); // R3
                end
                prev6_q     <= rd_data_o[6];
                have_prev_q <= 1'b1;
            end
        end
    end

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_i && cur_prog) |=> (rd_oe_o && rd_data_o[7] == ~$past(cur_d7))) else $error("program poll bit"); // R1

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_i && !cur_prog) |=> (rd_oe_o && rd_data_o[7] == 1'b0)) else $error("erase poll bit"); // R2

    AST_WRITE_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pe_o |=> !busy_o) else $error("program pulse not in last busy cycle"); // R4

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!arr_pe_o && !arr_ee_o && !rdy_low_o)) else $error("array write while idle"); // R4

    AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid_i && lock_i && req_in_boot) |=> !busy_o) else $error("locked request taken"); // R7

    AST_BOOT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ee_o && cur_lock && cur_chip) |-> ({1'b0, arr_addr_o} >= (ADDR_W+1)'(BOOT_WORDS))) else $error("boot word filled under lock"); // R7

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rd_oe_o) else $error("read not answered"); // R10

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rd_oe_o) else $error("drive without read"); // R10

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!busy_o && !rdy_low_o && !rd_oe_o) else $error("active in reset"); // R9
        end
    end

endmodule

bind pe_status_ctrl pe_status_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PAGE_WORDS  (PAGE_WORDS),
    .BLOCK_WORDS (BLOCK_WORDS),
    .BOOT_WORDS  (BOOT_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_data_i  (req_data_i),
    .lock_i      (lock_i),
    .rd_i        (rd_i),
    .busy_o      (busy_o),
    .rdy_low_o   (rdy_low_o),
    .rd_oe_o     (rd_oe_o),
    .rd_data_o   (rd_data_o),
    .arr_pe_o    (arr_pe_o),
    .arr_ee_o    (arr_ee_o),
    .arr_addr_o  (arr_addr_o)
);

// File: tb/pe_status_ctrl_bench.sv
module pe_status_ctrl_bench;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam int PGW = 4;
    localparam int BKW = 16;
    localparam int BOOTW = 8;
    localparam int T_PROG = 12;
    localparam int T_PAGE = 10;
    localparam int T_BLOCK = 24;
    localparam int T_CHIP = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic lock = 1'b0;
    logic rd = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic busy, rdy_low, rd_oe, arr_pe, arr_ee;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] arr_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    pe_status_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PGW), .BLOCK_WORDS(BKW), .BOOT_WORDS(BOOTW),
        .PROG_CYC(T_PROG), .PAGE_CYC(T_PAGE), .BLOCK_CYC(T_BLOCK), .CHIP_CYC(T_CHIP)
    ) u_pe_status_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_addr_i(req_addr), .req_data_i(req_data), .lock_i(lock), .rd_i(rd),
        .rd_addr_i(rd_addr), .busy_o(busy), .rdy_low_o(rdy_low), .rd_oe_o(rd_oe),
        .rd_data_o(rd_data), .arr_pe_o(arr_pe), .arr_ee_o(arr_ee), .arr_addr_o(arr_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 16'h2b47) ^ 16'hc3a5);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'((a * 16'h0d1f) + 16'h7e19);
    endfunction

    // model of the array after an accepted operation
    task automatic model_apply(input logic [1:0] op, input int addr, input logic [DW-1:0] data, input bit lk);
        int base, span;
        case (op)
            2'b00: begin base = addr; span = 0; model[addr] = model[addr] & data; end
            2'b01: begin base = addr - (addr % PGW); span = PGW; end
            2'b10: begin base = addr - (addr % BKW); span = BKW; end
            default: begin base = 0; span = DEPTH; end
        endcase
        for (int i = 0; i < span; i++) begin
            if (!(lk && op == 2'b11 && (base + i) < BOOTW)) model[base + i] = '1;
        end
    endtask

    function automatic int exp_dur(input logic [1:0] op);
        case (op)
            2'b00: return T_PROG;
            2'b01: return (T_PAGE > PGW) ? T_PAGE : PGW;
            2'b10: return (T_BLOCK > BKW) ? T_BLOCK : BKW;
            default: return (T_CHIP > DEPTH) ? T_CHIP : DEPTH;
        endcase
    endfunction

    task automatic launch(input logic [1:0] op, input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100000) begin
            if (!rdy_low) check(1'b0, "R4 ready line low while busy", 32'(rdy_low), 32'd1);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input int addr, input logic [DW-1:0] data);
        int n;
        launch(op, addr, data);
        wait_idle(n);
        check(n == exp_dur(op), "R4 busy duration", 32'(n), 32'(exp_dur(op)));
        model_apply(op, addr, data, lock);
    endtask

    task automatic do_read(input int addr, output logic [DW-1:0] v, output logic oe);
        @(negedge clk);
        rd = 1'b1; rd_addr = AW'(addr);
        @(negedge clk);
        rd = 1'b0;
        v = rd_data; oe = rd_oe;
    endtask

    task automatic read_all(input string req);
        logic [DW-1:0] v;
        logic oe;
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, v, oe);
            check(oe === 1'b1 && v === model[a], req, {15'b0, oe, v}, {16'h0001, model[a]});
        end
    endtask

    task automatic poll_reads(input int cnt, input bit inv7, input string req);
        logic [DW-1:0] v;
        logic oe;
        logic [DW-1:0] e;
        for (int k = 0; k < cnt; k++) begin
            do_read(0, v, oe);
            e = '0;
            e[7] = inv7;
            e[6] = k[0];
            check(oe === 1'b1 && v === e, req, {15'b0, oe, v}, {16'h0001, e});
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        logic oe;
        int n;

        // reset state (R9)
        repeat (3) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        check(!busy && !rdy_low && !rd_oe, "R9 idle and undriven in reset", {busy, rdy_low, rd_oe}, 0);
        rd = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_oe === 1'b0, "R10 no drive without read", 32'(rd_oe), 0);

        // full erase then AND-program sweeps (R6, R5, R10)
        run_op(2'b11, 0, '0);
        read_all("R6 chip erase fill");
        for (int a = 0; a < DEPTH; a++) run_op(2'b00, a, pat_a(a));
        read_all("R5 first program");
        for (int a = 0; a < DEPTH; a++) run_op(2'b00, a, pat_b(a));
        read_all("R5 second program ANDs");

        // page and block erase ranges (R6)
        run_op(2'b01, 22, '0);
        run_op(2'b01, 1, '0);
        read_all("R6 page erase range");
        run_op(2'b10, 37, '0);
        read_all("R6 block erase range");

        // program polling (R1, R3)
        launch(2'b00, 50, 16'h00F0);
        poll_reads(3, 1'b0, "R1 R3 program status word");
        wait_idle(n);
        model_apply(2'b00, 50, 16'h00F0, 1'b0);
        do_read(50, v, oe);
        check(v === model[50], "R1 true data after program", v, model[50]);
        launch(2'b00, 51, 16'h7F00);
        poll_reads(3, 1'b1, "R1 R3 status with bit7 low data");
        wait_idle(n);
        model_apply(2'b00, 51, 16'h7F00, 1'b0);
        do_read(51, v, oe);
        check(v === model[51], "R1 true data after program", v, model[51]);

        // erase polling (R2, R3)
        launch(2'b01, 9, '0);
        poll_reads(3, 1'b0, "R2 R3 erase status word");
        wait_idle(n);
        model_apply(2'b01, 9, '0, 1'b0);
        read_all("R2 erase completes");

        // requests while busy are ignored (R8)
        launch(2'b00, 60, 16'h0000);
        launch(2'b00, 61, 16'h0000);
        launch(2'b10, 61, 16'h0000);
        wait_idle(n);
        model_apply(2'b00, 60, 16'h0000, 1'b0);
        read_all("R8 busy requests dropped");

        // lock behaviour (R7)
        run_op(2'b00, 5, 16'h0000);
        lock = 1'b1;
        launch(2'b00, 3, 16'h0000);
        check(busy === 1'b0, "R7 locked program refused", 32'(busy), 0);
        launch(2'b01, 4, 16'h0000);
        check(busy === 1'b0, "R7 locked page erase refused", 32'(busy), 0);
        launch(2'b10, 2, 16'h0000);
        check(busy === 1'b0, "R7 locked block erase refused", 32'(busy), 0);
        read_all("R7 locked requests change nothing");
        run_op(2'b00, 9, 16'h0000);
        run_op(2'b11, 0, '0);
        read_all("R7 locked chip erase keeps boot words");
        lock = 1'b0;

        // reset abort (R9)
        launch(2'b00, 40, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !rdy_low && !rd_oe, "R9 abort clears outputs", {busy, rdy_low, rd_oe}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(40, v, oe);
        check(v === model[40], "R9 aborted program leaves word", v, model[40]);
        run_op(2'b00, 40, 16'h1234);
        do_read(40, v, oe);
        check(v === model[40], "R9 normal after reset", v, model[40]);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule